// File: doc/BRIEF.md
# Per-Load Stride Prefetch Table

This block watches the stream of executed loads and learns, for each static load instruction, whether its data addresses advance by a constant step. Each load presents its program counter and the data address it touched. The block keeps a small table, one entry per load, that holds the last address and the step last seen. When a load repeats the step it took last time, the block asks for the line one step further ahead.

The table is direct-mapped. Some low bits of the load's program counter select the entry, and the remaining upper bits serve as its tag. A load whose tag does not match takes over the entry without producing a request. The block emits a registered request as a valid pulse with an address. Caches, memory ports and request queues are outside this block.

Top module: `stride_prefetch_table`

## Requirements
- R1: After synchronous reset `pf_valid` is low and every table entry is empty, so the first load to any entry issues no request.
- R2: A load whose tag misses, or that hits an empty entry, takes over the entry: last address = load address, step = 0, entry marked valid. No request is issued.
- R3: On a tag hit the delta is the load address minus the stored last address, modulo 2^ADDR_W. When the delta equals the stored step and is non-zero, a request for load address + step is issued.
- R4: Every load that hits writes the load address into the last address and the delta into the step. A load whose delta differs from the stored step issues no request and retrains the step.
- R5: A step of zero never issues a request, even when the delta matches it.
- R6: PC bits [IDX_W+1:2] select one of 2^IDX_W entries and PC bits [PC_W-1:IDX_W+2] form the tag. A load with a different tag at the same index replaces the entry.
- R7: `pf_valid` is high for exactly the one cycle after the clock edge that samples the triggering load. Cycles with `ld_valid` low produce no request and leave the table unchanged.
- R8: Negative steps are handled by modulo arithmetic, and the request address wraps modulo 2^ADDR_W.
- R9: PC bits [1:0] are ignored. Loads whose PCs differ only in those bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | An executed load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Data address of the load |
| pf_valid | output | 1 | Prefetch request pulse |
| pf_addr | output | ADDR_W | Prefetch request address |

## Verification
Each request is due exactly one cycle after the edge that samples its load. The table update from a load is visible to the very next load, including a load in the following cycle. The driver task applies one load or one idle cycle per clock at the falling edge. It also pushes the expected request, worked out from a separate model of the table, into a queue. The monitor pops one item two nanoseconds after every rising edge, so each popped item is compared in the single cycle in which its response should appear. Every cycle with no request due must show `pf_valid` low.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

    localparam int DEF_PC_W   = 32;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_IDX_W  = 4;

    typedef enum logic [1:0] {
        LK_ALLOC = 2'd0,
        LK_TRAIN = 2'd1,
        LK_FIRE  = 2'd2
    } lookup_kind_t;

    function automatic logic kind_fires(input lookup_kind_t k);
        return k == LK_FIRE;
    endfunction

endpackage

// File: rtl/spt_entry_store.sv
module spt_entry_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    parameter int ADDR_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_last,
    output logic [ADDR_W-1:0] rd_step,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_last,
    input  logic [ADDR_W-1:0] wr_step
);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] step;
    } slot_t;

    slot_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slots[g].valid <= 1'b1;
                slots[g].tag   <= wr_tag;
                slots[g].last  <= wr_last;
                slots[g].step  <= wr_step;
            end
        end
    end

    slot_t rd_slot;
    always_comb begin
        rd_slot  = slots[rd_idx];
        rd_valid = rd_slot.valid;
        rd_tag   = rd_slot.tag;
        rd_last  = rd_slot.last;
        rd_step  = rd_slot.step;
    end

    // R2
    slot_marked_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slots[$past(wr_idx)].valid && slots[$past(wr_idx)].last == $past(wr_last));

endmodule

// File: rtl/spt_lookup_eval.sv
module spt_lookup_eval
    import stride_pf_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [ADDR_W-1:0] ent_last,
    input  logic [ADDR_W-1:0] ent_step,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output lookup_kind_t      kind,
    output logic [ADDR_W-1:0] next_step,
    output logic [ADDR_W-1:0] target
);

    logic              hit;
    logic [ADDR_W-1:0] delta;

    always_comb begin
        idx   = pc[IDX_W+1:2];
        tag   = pc[PC_W-1:IDX_W+2];
        hit   = ent_valid && (ent_tag == tag);
        delta = addr - ent_last;
        if (!hit) begin
            kind      = LK_ALLOC;
            next_step = '0;
        end else begin
            kind      = ((delta == ent_step) && (delta != '0)) ? LK_FIRE : LK_TRAIN;
            next_step = delta;
        end
        target = addr + ent_step;
    end

endmodule

// File: rtl/stride_prefetch_table.sv
module stride_prefetch_table
    import stride_pf_pkg::*;
#(
    parameter int PC_W   = DEF_PC_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int IDX_W  = DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              ent_valid;
    logic [TAG_W-1:0]  ent_tag;
    logic [ADDR_W-1:0] ent_last;
    logic [ADDR_W-1:0] ent_step;
    lookup_kind_t      lk_kind;
    logic [ADDR_W-1:0] lk_next_step;
    logic [ADDR_W-1:0] lk_target;

    spt_entry_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_idx),
        .rd_valid(ent_valid),
        .rd_tag  (ent_tag),
        .rd_last (ent_last),
        .rd_step (ent_step),
        .wr_en   (ld_valid),
        .wr_idx  (lk_idx),
        .wr_tag  (lk_tag),
        .wr_last (ld_addr),
        .wr_step (lk_next_step)
    );

    spt_lookup_eval #(
        .PC_W  (PC_W),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_eval (
        .pc       (ld_pc),
        .addr     (ld_addr),
        .ent_valid(ent_valid),
        .ent_tag  (ent_tag),
        .ent_last (ent_last),
        .ent_step (ent_step),
        .idx      (lk_idx),
        .tag      (lk_tag),
        .kind     (lk_kind),
        .next_step(lk_next_step),
        .target   (lk_target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= ld_valid && kind_fires(lk_kind);
            if (ld_valid && kind_fires(lk_kind)) begin
                pf_addr <= lk_target;
            end
        end
    end

    // R7
    pf_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> $past(ld_valid));

    // R5
    pf_nonzero_step_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> pf_addr != $past(ld_addr));

    // R3
    pf_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> $past(ent_valid) && $past(ent_tag) == $past(lk_tag));

    // R4
    pf_step_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> $past(ld_addr) - $past(ent_last) == $past(ent_step));

endmodule

// File: tb/test_stride_prefetch_table.sv
module test_stride_prefetch_table;

    localparam int PC_W   = 32;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 4;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_valid = 1'b0;
    logic [PC_W-1:0]   ld_pc = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              pf_valid;
    logic [ADDR_W-1:0] pf_addr;

    stride_prefetch_table #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_stride_prefetch_table (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_addr(ld_addr),
        .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic              v;
        logic [ADDR_W-1:0] a;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit running  = 0;

    logic              m_valid [DEPTH];
    logic [PC_W-1:0]   m_tag   [DEPTH];
    logic [ADDR_W-1:0] m_last  [DEPTH];
    logic [ADDR_W-1:0] m_step  [DEPTH];

    task automatic load(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a, input string req);
        exp_t e;
        int i;
        logic [PC_W-1:0] t;
        logic [ADDR_W-1:0] d;
        @(negedge clk);
        ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
        i = int'(pc[IDX_W+1:2]);
        t = pc >> (IDX_W + 2);
        e.v = 1'b0; e.a = '0; e.req = req;
        if (m_valid[i] && m_tag[i] == t) begin
            d = a - m_last[i];
            if (d == m_step[i] && d != 0) begin
                e.v = 1'b1; e.a = a + m_step[i];
            end
            m_step[i] = d;
        end else begin
            m_valid[i] = 1'b1; m_tag[i] = t; m_step[i] = '0;
        end
        m_last[i] = a;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            @(negedge clk);
            ld_valid = 1'b0; ld_pc = 32'hDEAD_BEE0; ld_addr = 32'h1234_5678;
            e.v = 1'b0; e.a = '0; e.req = "R7";
            exp_q.push_back(e);
        end
    endtask

    always @(posedge clk) begin
        if (running) begin
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (pf_valid !== e.v || (e.v && pf_addr !== e.a)) begin
                    n_fails++;
                    $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
                             e.req, pf_valid, pf_addr, e.v, e.a);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_last[i] = '0; m_step[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        n_checks++;
        if (pf_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: pf_valid=%0b expected 0 after reset", pf_valid);
        end
        running = 1;

        // R1 R2: first load allocates, no request
        load(32'h0000_0100, 32'h0000_1000, "R1/R2");
        // R3 R4: train step, then repeated step fires
        load(32'h0000_0100, 32'h0000_1040, "R4");
        load(32'h0000_0100, 32'h0000_1080, "R3");
        idle(1);
        load(32'h0000_0100, 32'h0000_10C0, "R3");
        idle(2);
        // R4: step change retrains, then fires on the new step
        load(32'h0000_0100, 32'h0000_1200, "R4");
        load(32'h0000_0100, 32'h0000_1340, "R4");
        load(32'h0000_0100, 32'h0000_1480, "R3");
        // R8: negative step
        load(32'h0000_0204, 32'h0000_5000, "R2");
        load(32'h0000_0204, 32'h0000_4FF8, "R8");
        load(32'h0000_0204, 32'h0000_4FF0, "R8");
        load(32'h0000_0204, 32'h0000_4FE8, "R8");
        // R8: wrap below zero
        load(32'h0000_0208, 32'h0000_0010, "R2");
        load(32'h0000_0208, 32'h0000_0008, "R8");
        load(32'h0000_0208, 32'h0000_0000, "R8");
        // R5: zero step never fires
        load(32'h0000_030C, 32'h0000_7700, "R2");
        load(32'h0000_030C, 32'h0000_7700, "R5");
        load(32'h0000_030C, 32'h0000_7700, "R5");
        load(32'h0000_030C, 32'h0000_7700, "R5");
        // R9: low PC bits ignored, shares the entry of 0x100
        load(32'h0000_0103, 32'h0000_15C0, "R9");
        load(32'h0000_0101, 32'h0000_1700, "R9");
        // R6: conflicting tag at same index replaces the entry
        load(32'h0000_1100, 32'h0000_9000, "R6");
        load(32'h0000_0100, 32'h0000_1840, "R6");
        load(32'h0000_0100, 32'h0000_1980, "R6");
        load(32'h0000_0100, 32'h0000_1AC0, "R6");
        // R6: distinct indexes interleaved keep separate state
        for (int k = 0; k < 5; k++) begin
            load(32'h0000_0410, 32'h0002_0000 + k * 32'h100, "R6");
            load(32'h0000_0414, 32'h0003_0000 - k * 32'h20, "R6");
        end
        idle(1);
        // R7: idle cycles between loads do not disturb training
        load(32'h0000_0410, 32'h0002_0500, "R7");
        idle(3);
        load(32'h0000_0410, 32'h0002_0600, "R7");
        idle(2);
        running = 1;
        @(posedge clk);
        #3;
        finish_run();
    end

endmodule